// File: doc/BRIEF.md
# 16-bit Timer Compare Channel

This block sits beside a free-running 16-bit timer and watches for the moment the timer count equals a programmable compare value. When a match is seen on a timer tick, it raises a sticky match flag one clock later. It also raises an interrupt request when interrupts are enabled and gives a one-clock match strobe to a separate waveform generator. The flag clears when the CPU acknowledges the interrupt, or when software writes a one to the clear bit.

The CPU reaches the 16-bit compare value over an 8-bit bus. A high-byte write is held in a temporary byte. A later low-byte write commits both bytes together, so the 16-bit value always changes in one step. In PWM operation the committed value goes into a shadow buffer. The buffer is copied into the active register only on an update strobe, which comes from either the counter's TOP event or its BOTTOM event. Outside PWM operation the committed value goes straight into the active register. The active value is also brought out, so the counter can use it as its TOP value, which sets both the counter resolution and the waveform period.

Top module: `ocu_top`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `match_flag`, `irq`, `match_pulse` and `cmp_active` are all zero, and the temporary byte and the shadow buffer are zero.
- R2: If `tick` is high and `count` equals `cmp_active` at a clock edge, `match_flag` is 1 after that edge. If `tick` is low, equality does not set the flag.
- R3: `match_pulse` is high for exactly the clock after each edge at which `tick` was high and `count` equalled `cmp_active`, and low otherwise.
- R4: After each edge, `irq` equals the new `match_flag` ANDed with the `irq_en` value sampled at that edge.
- R5: A high `int_ack` at an edge clears `match_flag`.
- R6: A bus write to address 2 with data bit 0 set clears `match_flag`. A write to address 2 with bit 0 clear leaves the flag unchanged.
- R7: When a flag set (R2) and a clear (R5 or R6) occur at the same edge, the flag ends up 1.
- R8: A write to address 1 (high byte) only loads the temporary byte and leaves `cmp_active` unchanged. A write to address 0 (low byte) commits {temporary byte, written byte} as one 16-bit value.
- R9: When `pwm_mode` is 0, a committed value appears on `cmp_active` after the edge at which the low byte is written.
- R10: When `pwm_mode` is 1, a committed value goes only into the shadow buffer, and `cmp_active` holds its value at every edge without an update strobe.
- R11: When `pwm_mode` is 1, the update strobe is `at_top` if `upd_sel` is 0 and `at_bottom` if `upd_sel` is 1. On the strobe, the buffer value, as it was before that edge, is copied into `cmp_active`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer clock enable; one pulse per timer step |
| count | input | 16 | Current timer count |
| pwm_mode | input | 1 | 1 = buffered PWM operation, 0 = direct write |
| upd_sel | input | 1 | Update strobe source: 0 = TOP event, 1 = BOTTOM event |
| at_top | input | 1 | Counter is at TOP (one-cycle strobe) |
| at_bottom | input | 1 | Counter is at BOTTOM (one-cycle strobe) |
| irq_en | input | 1 | Interrupt enable |
| int_ack | input | 1 | Interrupt acknowledge; clears the flag |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | 2 | 0 = low byte, 1 = high byte, 2 = flag clear |
| bus_wdata | input | 8 | Bus write data |
| match_flag | output | 1 | Sticky compare-match flag |
| irq | output | 1 | Interrupt request |
| match_pulse | output | 1 | One-clock match strobe for the waveform generator |
| cmp_active | output | 16 | Active compare value; also usable as the counter TOP |

## Verification
The assertions assume that every input is synchronous to `clk` and stable across the sampling edge. They also assume `at_top` and `at_bottom` are plain level inputs; the block treats them as strobes only through the edges at which they are high. The stimulus changes every input on the falling clock edge only. It steers `count` toward the current active value often, so that matches, and matches that coincide with clears, happen many times. It drives mode changes, strobes, acknowledges and bus writes in random mixes, all within that timing.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
  localparam int ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    SEL_LO   = 2'd0,
    SEL_HI   = 2'd1,
    SEL_FLAG = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;
endpackage

// File: rtl/ocu_bus_port.sv
module ocu_bus_port
  import ocu_pkg::*;
#(
  parameter int W  = 16,
  parameter int BW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BW-1:0]     wdata,
  output logic              commit,
  output logic [W-1:0]      commit_val,
  output logic              clr_req
);
  localparam int TW = W - BW;

  logic [TW-1:0] temp_q;

  always_ff @(posedge clk) begin
    if (rst) temp_q <= '0;
    else if (we && addr == SEL_HI) temp_q <= wdata[TW-1:0];
  end

  always_comb begin
    commit     = we && (addr == SEL_LO);
    commit_val = {temp_q, wdata};
    clr_req    = we && (addr == SEL_FLAG) && wdata[0];
  end
endmodule

// File: rtl/ocu_cmp_store.sv
module ocu_cmp_store #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         commit,
  input  logic [W-1:0] commit_val,
  input  logic         pwm_mode,
  input  logic         upd_stb,
  output logic [W-1:0] active
);
  logic [W-1:0] shadow_q;
  logic [W-1:0] active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (commit && pwm_mode) shadow_q <= commit_val;
      if (pwm_mode) begin
        if (upd_stb) active_q <= shadow_q;
      end else if (commit) begin
        active_q <= commit_val;
      end
    end
  end

  assign active = active_q;
endmodule

// File: rtl/ocu_match.sv
module ocu_match #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] count,
  input  logic [W-1:0] active,
  input  logic         irq_en,
  input  logic         ack,
  input  logic         clr_req,
  output logic         flag,
  output logic         irq,
  output logic         pulse
);
  logic hit;
  logic flag_d;
  logic flag_q, irq_q, pulse_q;

  always_comb begin
    hit = tick && (count == active);
    if (hit)                 flag_d = 1'b1;
    else if (ack || clr_req) flag_d = 1'b0;
    else                     flag_d = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      irq_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      irq_q   <= flag_d && irq_en;
      pulse_q <= hit;
    end
  end

  assign flag  = flag_q;
  assign irq   = irq_q;
  assign pulse = pulse_q;
endmodule

// File: rtl/ocu_top.sv
module ocu_top
  import ocu_pkg::*;
#(
  parameter int W  = 16,
  parameter int BW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [W-1:0]      count,
  input  logic              pwm_mode,
  input  logic              upd_sel,
  input  logic              at_top,
  input  logic              at_bottom,
  input  logic              irq_en,
  input  logic              int_ack,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BW-1:0]     bus_wdata,
  output logic              match_flag,
  output logic              irq,
  output logic              match_pulse,
  output logic [W-1:0]      cmp_active
);
  logic         commit;
  logic [W-1:0] commit_val;
  logic         clr_req;
  logic         upd_stb;

  assign upd_stb = pwm_mode && (upd_sel ? at_bottom : at_top);

  ocu_bus_port #(.W(W), .BW(BW)) u_bus (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .commit(commit), .commit_val(commit_val), .clr_req(clr_req)
  );

  ocu_cmp_store #(.W(W)) u_store (
    .clk(clk), .rst(rst), .commit(commit), .commit_val(commit_val),
    .pwm_mode(pwm_mode), .upd_stb(upd_stb), .active(cmp_active)
  );

  ocu_match #(.W(W)) u_match (
    .clk(clk), .rst(rst), .tick(tick), .count(count), .active(cmp_active),
    .irq_en(irq_en), .ack(int_ack), .clr_req(clr_req),
    .flag(match_flag), .irq(irq), .pulse(match_pulse)
  );
endmodule

// File: rtl/ocu_chk.sv
module ocu_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic [W-1:0] count,
  input logic         pwm_mode,
  input logic         upd_sel,
  input logic         at_top,
  input logic         at_bottom,
  input logic         int_ack,
  input logic         match_flag,
  input logic         irq,
  input logic         match_pulse,
  input logic [W-1:0] cmp_active
);
  // R2
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && count == cmp_active) |=> match_flag);

  // R3
  pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
    (!(tick && count == cmp_active)) |=> !match_pulse);

  // R4
  irq_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> match_flag);

  // R5
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (int_ack && !(tick && count == cmp_active)) |=> !match_flag);

  // R10
  hold_active_chk: assert property (@(posedge clk) disable iff (rst)
    (pwm_mode && !(upd_sel ? at_bottom : at_top)) |=> $stable(cmp_active));
endmodule

bind ocu_top ocu_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .count(count), .pwm_mode(pwm_mode),
  .upd_sel(upd_sel), .at_top(at_top), .at_bottom(at_bottom), .int_ack(int_ack),
  .match_flag(match_flag), .irq(irq), .match_pulse(match_pulse),
  .cmp_active(cmp_active)
);

// File: tb/sim_ocu_top.sv
module sim_ocu_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 0, pwm_mode = 0, upd_sel = 0, at_top = 0, at_bottom = 0;
  logic        irq_en = 0, int_ack = 0, bus_we = 0;
  logic [15:0] count = 0;
  logic [1:0]  bus_addr = 0;
  logic [7:0]  bus_wdata = 0;
  logic        match_flag, irq, match_pulse;
  logic [15:0] cmp_active;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  int m_temp = 0, m_buf = 0, m_act = 0;
  bit m_flag = 0, m_irq = 0, m_pulse = 0;

  always #10 clk = ~clk;

  ocu_top u0 (
    .clk(clk), .rst(rst), .tick(tick), .count(count), .pwm_mode(pwm_mode),
    .upd_sel(upd_sel), .at_top(at_top), .at_bottom(at_bottom), .irq_en(irq_en),
    .int_ack(int_ack), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .match_flag(match_flag), .irq(irq), .match_pulse(match_pulse),
    .cmp_active(cmp_active)
  );

  always @(posedge clk) begin
    bit hit, clr, stb;
    int nact;
    if (rst) begin
      m_temp = 0; m_buf = 0; m_act = 0; m_flag = 0; m_irq = 0; m_pulse = 0;
    end else begin
      hit  = tick && (int'(count) == m_act);
      clr  = int_ack || (bus_we && bus_addr == 2 && bus_wdata[0]);
      stb  = pwm_mode && (upd_sel ? at_bottom : at_top);
      nact = m_act;
      if (stb) nact = m_buf;
      if (bus_we && bus_addr == 0) begin
        if (pwm_mode) m_buf = m_temp * 256 + int'(bus_wdata);
        else nact = m_temp * 256 + int'(bus_wdata);
      end
      if (bus_we && bus_addr == 1) m_temp = int'(bus_wdata);
      if (hit) m_flag = 1;
      else if (clr) m_flag = 0;
      m_irq   = m_flag && irq_en;
      m_pulse = hit;
      m_act   = nact;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(match_flag == m_flag, "R2 R5 R6 R7 flag", match_flag, m_flag);
    chk(irq == m_irq, "R4 irq", irq, m_irq);
    chk(match_pulse == m_pulse, "R3 pulse", match_pulse, m_pulse);
    chk(int'(cmp_active) == m_act, "R8 R9 R10 R11 active", cmp_active, m_act);
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    tick = 0; at_top = 0; at_bottom = 0; int_ack = 0; bus_we = 0;
  endtask

  task automatic wr(input int a, input int d);
    bus_we = 1; bus_addr = 2'(a); bus_wdata = 8'(d);
    step();
    bus_we = 0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R1: reset state
    chk(match_flag == 0 && irq == 0 && match_pulse == 0 && cmp_active == 0,
        "R1 reset", {match_flag, irq, match_pulse}, 0);
    rst = 0;
    step();
    // R8 R9: direct write, high byte alone changes nothing
    wr(1, 8'h12);
    chk(cmp_active == 16'h0000, "R8 high only", cmp_active, 0);
    wr(0, 8'h34);
    chk(cmp_active == 16'h1234, "R9 direct", cmp_active, 16'h1234);
    // R2: no tick, no set
    count = 16'h1234; step();
    chk(match_flag == 0, "R2 no tick", match_flag, 0);
    irq_en = 1; tick = 1; step(); tick = 0;
    chk(match_flag == 1 && match_pulse == 1, "R2 R3 set", match_flag, 1);
    chk(irq == 1, "R4 irq", irq, 1);
    step();
    chk(match_pulse == 0, "R3 one clock", match_pulse, 0);
    // R6: write zero ignored, write one clears
    wr(2, 8'h00);
    chk(match_flag == 1, "R6 zero write", match_flag, 1);
    wr(2, 8'h01);
    chk(match_flag == 0, "R6 clear", match_flag, 0);
    // R7: set beats ack
    tick = 1; int_ack = 1; step(); idle();
    chk(match_flag == 1, "R7 set wins", match_flag, 1);
    // R5
    int_ack = 1; step(); idle();
    chk(match_flag == 0, "R5 ack", match_flag, 0);
    // R10 R11: PWM buffering
    pwm_mode = 1; upd_sel = 0;
    wr(1, 8'hAB); wr(0, 8'hCD);
    chk(cmp_active == 16'h1234, "R10 buffered", cmp_active, 16'h1234);
    at_bottom = 1; step(); idle();
    chk(cmp_active == 16'h1234, "R11 wrong strobe", cmp_active, 16'h1234);
    at_top = 1; step(); idle();
    chk(cmp_active == 16'hABCD, "R11 top update", cmp_active, 16'hABCD);
    upd_sel = 1; wr(0, 8'h01);
    at_top = 1; step(); idle();
    chk(cmp_active == 16'hABCD, "R11 top ignored", cmp_active, 16'hABCD);
    at_bottom = 1; step(); idle();
    chk(cmp_active == 16'hAB01, "R11 bottom update", cmp_active, 16'hAB01);
    // random mix, compared against the model every clock
    for (int i = 0; i < 4000; i++) begin
      tick      = ($urandom % 2) == 0;
      count     = ($urandom % 3 == 0) ? 16'(m_act) : 16'($urandom);
      pwm_mode  = ($urandom % 8) < 5;
      upd_sel   = $urandom % 2;
      at_top    = ($urandom % 6) == 0;
      at_bottom = ($urandom % 6) == 0;
      irq_en    = ($urandom % 4) != 0;
      int_ack   = ($urandom % 7) == 0;
      bus_we    = ($urandom % 3) == 0;
      bus_addr  = 2'($urandom);
      bus_wdata = 8'($urandom);
      if ($urandom % 200 == 0) rst = 1; else rst = 0;
      step();
    end
    rst = 0; idle();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule